// File: doc/BRIEF.md
# Program-Only-Clears Flash Word Model

This block is a synthesizable behavioural model of a small non-volatile array. It sits behind a flash controller and gives that controller the same rules a real flash array imposes. A program operation can only turn 1 bits into 0. Each word accepts a limited number of programs before its page must be erased. An erase returns a whole region to all ones.

The array has two regions. The code region is split into `PAGES` pages of `WPP` words each. The configuration region is a separate single page of `CFG_WORDS` words. The controller sends one request at a time. Each request has an operation code, a region select, a word address and a 32-bit data word.

Each accepted operation keeps the block busy for a fixed number of cycles, and the array changes only on the last of those cycles. Reads are combinational and independent of requests, so a read during an operation returns the old contents. When a word is programmed more often than its budget allows, the model stores an undefined value in it and raises a violation flag.

Top module: `flash_cell_array`

## Requirements
- R1: After reset every word in both regions reads 32'hFFFF_FFFF, `busy_o` is 0 and `violation_o` is 0.
- R2: A program (`req_op_i`=0) with `req_cfg_i`=0 targets the code region and with `req_cfg_i`=1 targets the configuration region. When the operation completes, the word holds the bitwise AND of its old value and `req_data_i`.
- R3: A word can be programmed `MAX_PROG` (default 2) times after reset or after its last erase, and each of those programs applies the rule in R2. Programs that clear no bits still count toward this limit.
- R4: A program to a word that has already used its budget sets `violation_o`. The word then holds `FILL_WORD` (default 32'hDEAD_BEEF) when `FILL_X`=0, or X when `FILL_X`=1.
- R5: A page erase (`req_op_i`=1) sets every word of the code page `req_addr_i / WPP` to all ones and restores that page's program budgets. Other pages and the configuration region keep their contents.
- R6: A configuration erase (`req_op_i`=3) sets every configuration word to all ones and restores their program budgets. The code region keeps its contents.
- R7: A full erase (`req_op_i`=2) sets both regions to all ones and restores every program budget.
- R8: After a request is accepted, `busy_o` is 1 for exactly `PROG_CYCLES` cycles for a program, `PAGE_ERASE_CYCLES` cycles for a page or configuration erase, and `FULL_ERASE_CYCLES` cycles for a full erase. Reads made while `busy_o` is 1 return the contents from before the operation.
- R9: A request presented while `busy_o` is 1 is ignored. It changes no word.
- R10: `violation_o` stays set until reset. No erase clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, accepted when not busy |
| req_op_i | input | 2 | 0 program, 1 page erase, 2 full erase, 3 configuration erase |
| req_cfg_i | input | 1 | Region select for program: 1 selects the configuration region |
| req_addr_i | input | ADDR_W | Word index, or any word of the page to erase |
| req_data_i | input | 32 | Program data, with 1 meaning keep the bit |
| busy_o | output | 1 | Operation in progress |
| violation_o | output | 1 | Sticky program-budget violation |
| rd_cfg_i | input | 1 | Read region select |
| rd_addr_i | input | ADDR_W | Read word index |
| rd_data_o | output | 32 | Read data |

## Verification
The bench programs the same word repeatedly with patterns that overlap. A model that overwrote the word instead of ANDing it would return the last pattern rather than the intersection of the patterns. A third program must produce the fill word and raise the flag, so a budget counter that is off by one is exposed at once.

Erases are checked against neighbouring pages and against the other region, which catches decode that is too wide. After a page erase the bench programs the same word twice more, which catches counters that were not cleared. The bench samples a word in the middle of an operation, which catches an early commit. It also fires a request while the block is busy, which catches gating that lets the request through. Busy lengths are counted for each class of operation.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    OP_PROG       = 2'd0,
    OP_PAGE_ERASE = 2'd1,
    OP_FULL_ERASE = 2'd2,
    OP_CFG_ERASE  = 2'd3
  } flash_op_e;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int DUR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= dur_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == DUR_W'(1));

  // R8: busy only drops through the commit cycle
  assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/flash_region.sv
module flash_region #(
  parameter int          WORDS     = 16,
  parameter int          WPP       = 4,
  parameter int          MAX_PROG  = 2,
  parameter bit          FILL_X    = 1'b0,
  parameter logic [31:0] FILL_WORD = 32'hDEAD_BEEF,
  localparam int         AW        = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int         CW        = $clog2(MAX_PROG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic          erase_page_i,
  input  logic          erase_all_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [31:0]   rd_data_o,
  output logic          over_o
);
  localparam logic [31:0] FILL_VAL = FILL_X ? {32{1'bx}} : FILL_WORD;
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PROG);

  logic [31:0]   mem_q [WORDS];
  logic [CW-1:0] cnt_q [WORDS];

  assign over_o = prog_i && (cnt_q[addr_i] == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) begin
        mem_q[i] <= '1;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (erase_all_i ||
            (erase_page_i && (int'(addr_i) / WPP == i / WPP))) begin
          mem_q[i] <= '1;
          cnt_q[i] <= '0;
        end else if (prog_i && (int'(addr_i) == i)) begin
          if (cnt_q[i] == CNT_MAX) begin
            mem_q[i] <= FILL_VAL;
          end else begin
            mem_q[i] <= mem_q[i] & data_i;
            cnt_q[i] <= cnt_q[i] + 1'b1;
          end
        end
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[addr_i] <= CNT_MAX);
  assert_prog_and_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !over_o && !erase_all_i && !erase_page_i) |=>
      mem_q[$past(addr_i)] == ($past(mem_q[addr_i]) & $past(data_i)));
  assert_erase_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |=> (mem_q[0] == '1) && (cnt_q[0] == '0));
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_pkg::*;
#(
  parameter int          PAGES             = 4,
  parameter int          WPP               = 4,
  parameter int          CFG_WORDS         = 2,
  parameter int          MAX_PROG          = 2,
  parameter int          PROG_CYCLES       = 3,
  parameter int          PAGE_ERASE_CYCLES = 5,
  parameter int          FULL_ERASE_CYCLES = 8,
  parameter bit          FILL_X            = 1'b0,
  parameter logic [31:0] FILL_WORD         = 32'hDEAD_BEEF,
  localparam int         CODE_WORDS        = PAGES * WPP,
  localparam int         ADDR_W            = $clog2(CODE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_cfg_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_data_i,
  output logic              busy_o,
  output logic              violation_o,
  input  logic              rd_cfg_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o
);
  localparam int MAX_DUR = (FULL_ERASE_CYCLES > PAGE_ERASE_CYCLES) ?
    ((FULL_ERASE_CYCLES > PROG_CYCLES) ? FULL_ERASE_CYCLES : PROG_CYCLES) :
    ((PAGE_ERASE_CYCLES > PROG_CYCLES) ? PAGE_ERASE_CYCLES : PROG_CYCLES);
  localparam int DUR_W = $clog2(MAX_DUR + 1);
  localparam int CAW   = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

  flash_op_e         op_q;
  logic              cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic              viol_q;
  logic              start, done;
  logic [DUR_W-1:0]  dur;
  logic [31:0]       code_rd, cfg_rd;
  logic              code_over, cfg_over;

  assign start = req_valid_i && !busy_o;

  always_comb begin
    unique case (flash_op_e'(req_op_i))
      OP_PROG:       dur = DUR_W'(PROG_CYCLES);
      OP_FULL_ERASE: dur = DUR_W'(FULL_ERASE_CYCLES);
      default:       dur = DUR_W'(PAGE_ERASE_CYCLES);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_PROG;
      cfg_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '1;
    end else if (start) begin
      op_q   <= flash_op_e'(req_op_i);
      cfg_q  <= req_cfg_i;
      addr_q <= req_addr_i;
      data_q <= req_data_i;
    end
  end

  flash_op_timer #(.DUR_W(DUR_W)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .dur_i(dur), .busy_o, .done_o(done)
  );

  flash_region #(
    .WORDS(CODE_WORDS), .WPP(WPP), .MAX_PROG(MAX_PROG),
    .FILL_X(FILL_X), .FILL_WORD(FILL_WORD)
  ) u_code (
    .clk_i, .rst_ni,
    .prog_i      (done && op_q == OP_PROG && !cfg_q),
    .erase_page_i(done && op_q == OP_PAGE_ERASE),
    .erase_all_i (done && op_q == OP_FULL_ERASE),
    .addr_i      (addr_q),
    .data_i      (data_q),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (code_rd),
    .over_o      (code_over)
  );

  flash_region #(
    .WORDS(CFG_WORDS), .WPP(CFG_WORDS), .MAX_PROG(MAX_PROG),
    .FILL_X(FILL_X), .FILL_WORD(FILL_WORD)
  ) u_cfg (
    .clk_i, .rst_ni,
    .prog_i      (done && op_q == OP_PROG && cfg_q),
    .erase_page_i(1'b0),
    .erase_all_i (done && (op_q == OP_FULL_ERASE || op_q == OP_CFG_ERASE)),
    .addr_i      (addr_q[CAW-1:0]),
    .data_i      (data_q),
    .rd_addr_i   (rd_addr_i[CAW-1:0]),
    .rd_data_o   (cfg_rd),
    .over_o      (cfg_over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= viol_q | code_over | cfg_over;
  end

  assign violation_o = viol_q;
  assign rd_data_o   = rd_cfg_i ? cfg_rd : code_rd;

  assert_viol_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q);
  assert_ignore_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(data_q) && $stable(addr_q) && $stable(op_q));
  assert_over_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_over || cfg_over) |=> violation_o);
endmodule

// File: tb/flash_cell_array_tb_top.sv
module flash_cell_array_tb_top;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic          req_cfg = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_data = '1;
  logic          busy, viol;
  logic          rd_cfg = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cell_array dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_cfg_i(req_cfg),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .busy_o(busy), .violation_o(viol),
    .rd_cfg_i(rd_cfg), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic cfg, input int a, input logic [31:0] exp);
    rd_cfg  = cfg;
    rd_addr = AW'(a);
    #1;
    check(req, rd_data, exp);
  endtask

  // issue op; optionally check a word mid-operation; return busy length
  task automatic do_op(input logic [1:0] op, input logic cfg, input int a,
                       input logic [31:0] d, output int len,
                       input bit mid = 1'b0, input logic mcfg = 1'b0,
                       input int ma = 0, input logic [31:0] mexp = '0);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cfg = cfg; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    len = 0;
    while (busy) begin
      len++;
      if (mid && len == 2) read_chk("R8 mid-op read", mcfg, ma, mexp);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    read_chk("R1 code word 0", 1'b0, 0, 32'hFFFF_FFFF);
    read_chk("R1 code word 15", 1'b0, 15, 32'hFFFF_FFFF);
    read_chk("R1 cfg word 1", 1'b1, 1, 32'hFFFF_FFFF);
    check("R1 busy", 32'(busy), 0);
    check("R1 violation", 32'(viol), 0);
  endtask

  task automatic t_program;
    int n;
    do_op(2'd0, 1'b0, 5, 32'hFFFF_00FF, n, 1'b1, 1'b0, 5, 32'hFFFF_FFFF);
    check("R8 program busy length", n, 3);
    read_chk("R2 first program", 1'b0, 5, 32'hFFFF_00FF);
    do_op(2'd0, 1'b0, 5, 32'h0F0F_FFFF, n);
    read_chk("R3 second program ANDs", 1'b0, 5, 32'h0F0F_00FF);
    check("R3 no violation within budget", 32'(viol), 0);
    do_op(2'd0, 1'b0, 9, 32'h1234_5678, n);
    read_chk("R2 other word", 1'b0, 9, 32'h1234_5678);
  endtask

  task automatic t_third;
    int n;
    do_op(2'd0, 1'b0, 5, 32'hFFFF_FFFF, n);
    check("R4 violation set", 32'(viol), 1);
    read_chk("R4 fill word", 1'b0, 5, 32'hDEAD_BEEF);
  endtask

  task automatic t_page_erase;
    int n;
    // page erase of page 1, request fired during busy must be dropped
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = AW'(6); req_data = '1;
    @(negedge clk);
    req_op = 2'd0; req_cfg = 1'b0; req_addr = AW'(0); req_data = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (busy) begin
      n++;
      if (n == 3) read_chk("R8 mid-erase old data", 1'b0, 5, 32'hDEAD_BEEF);
      @(negedge clk);
    end
    check("R8 page erase busy length", n, 5);
    read_chk("R9 busy request ignored", 1'b0, 0, 32'hFFFF_FFFF);
    check("R9 still idle", 32'(busy), 0);
    read_chk("R5 erased word", 1'b0, 5, 32'hFFFF_FFFF);
    read_chk("R5 neighbour page kept", 1'b0, 9, 32'h1234_5678);
    do_op(2'd0, 1'b0, 5, 32'hF0F0_F0F0, n);
    do_op(2'd0, 1'b0, 5, 32'hFF00_FF00, n);
    read_chk("R5 budget restored", 1'b0, 5, 32'hF000_F000);
    check("R10 violation sticky after erase", 32'(viol), 1);
  endtask

  task automatic t_cfg;
    int n;
    do_op(2'd0, 1'b1, 1, 32'h1234_5678, n);
    read_chk("R2 cfg program", 1'b1, 1, 32'h1234_5678);
    do_op(2'd0, 1'b0, 2, 32'hAAAA_5555, n);
    do_op(2'd3, 1'b0, 0, 32'h0, n);
    check("R8 cfg erase busy length", n, 5);
    read_chk("R6 cfg erased", 1'b1, 1, 32'hFFFF_FFFF);
    read_chk("R6 code kept", 1'b0, 2, 32'hAAAA_5555);
  endtask

  task automatic t_full;
    int n;
    do_op(2'd0, 1'b1, 0, 32'h0000_FFFF, n);
    do_op(2'd2, 1'b0, 0, 32'h0, n, 1'b1, 1'b1, 0, 32'h0000_FFFF);
    check("R8 full erase busy length", n, 8);
    read_chk("R7 code erased", 1'b0, 2, 32'hFFFF_FFFF);
    read_chk("R7 code erased 9", 1'b0, 9, 32'hFFFF_FFFF);
    read_chk("R7 cfg erased", 1'b1, 0, 32'hFFFF_FFFF);
    check("R10 violation after full erase", 32'(viol), 1);
  endtask

  task automatic t_rereset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset clears violation", 32'(viol), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_third();
        t_page_erase();
        t_cfg();
        t_full();
        t_rereset();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule